// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a memory device. Four wires reach it: a test clock, a mode-select line, a serial data input and a serial data output with its enable. It holds the sixteen-state test controller, a three-bit instruction register, a one-bit bypass register, a 32-bit hardwired identification register and a boundary register whose length is a parameter. The boundary register captures the device pin states in parallel.

The mode-select and data inputs are sampled on the rising test-clock edge. The serial output and its enable are retimed on the falling edge. Board test equipment shifts an instruction in, and that instruction picks which single data register sits between the serial input and output. Equipment then captures and shifts that register to read the identity code or the pin states, or passes data straight through with one stage of delay. Reset comes from an asynchronous active-low input, or from five rising clock edges with mode-select held high. Neither reset touches the memory function of the device.

Top module: `scan_tap`

## Requirements
- R1: The controller follows the standard sixteen-state test graph, and tms is sampled on each rising tck edge. A detour through Exit1-DR, Pause-DR and Exit2-DR back to Shift-DR neither adds nor loses any serial bit.
- R2: Five consecutive rising tck edges with tms high bring the controller to Test-Logic-Reset from any state. While in that state, the active instruction becomes IDCODE.
- R3: While trst_n is low, the controller is held in Test-Logic-Reset, the active instruction is IDCODE and tdo_oe is low. This holds asynchronously to tck.
- R4: tdo and tdo_oe change only on falling tck edges. tdo_oe is high exactly after falling edges that occur in Shift-IR or Shift-DR. At all other times it is low, and tdo is then treated as high impedance.
- R5: In Capture-IR, the instruction shift register is loaded with 3'b001. The first three bits seen at tdo are therefore 1, 0, 0.
- R6: Every selected register takes tdi at its most significant bit and presents its least significant bit at tdo. The path length is 3 for the instruction register, 1 for bypass, 32 for identification and BSR_LEN for the boundary register.
- R7: A shifted instruction becomes active only on the rising edge in Update-IR. Default codes: EXTEST=3'b000, IDCODE=3'b001, SAMPLE Z=3'b010, SAMPLE/PRELOAD=3'b100, BYPASS=3'b111.
- R8: Under BYPASS, Capture-DR clears the bypass bit. The first bit seen in Shift-DR is 0, and each later bit is the tdi bit from one shift earlier.
- R9: Under IDCODE, Capture-DR loads ID_VALUE with bit 0 forced to 1. That value is shifted out least significant bit first.
- R10: Under EXTEST, SAMPLE Z and SAMPLE/PRELOAD, Capture-DR loads bsr_pins into the boundary register, with bit i taken from pin i.
- R11: The reserved codes 3'b011, 3'b101 and 3'b110 select the bypass register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| bsr_pins | input | BSR_LEN | Pin states captured by the boundary register |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Output enable for tdo, updated on falling tck |

## Verification
The bound checker checks the following on every rising edge:
- tms held high keeps Test-Logic-Reset and, after five edges, forces it.
- Test-Logic-Reset restores IDCODE.
- Capture-IR leaves 01 in the low instruction bits.
- The active instruction moves only in Update-IR or reset.
- Bypass capture clears the bypass bit.
- tdo_oe matches the shift states.

The serial content of each path can only be shown by the bench's scenarios. These cover the identification code, the boundary capture under the three boundary instructions, bypass delay under BYPASS and the reserved codes, and path lengths. The scenarios also cover a Pause-DR detour, a late instruction update through Pause-IR, and five-edge resets entered from inside a shift. A behavioural model is compared with tdo and tdo_oe on every clock of those scenarios.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_EX2_DR = 4'h0,
    ST_EX1_DR = 4'h1,
    ST_SH_DR  = 4'h2,
    ST_PAU_DR = 4'h3,
    ST_SEL_IR = 4'h4,
    ST_UPD_DR = 4'h5,
    ST_CAP_DR = 4'h6,
    ST_SEL_DR = 4'h7,
    ST_EX2_IR = 4'h8,
    ST_EX1_IR = 4'h9,
    ST_SH_IR  = 4'hA,
    ST_PAU_IR = 4'hB,
    ST_IDLE   = 4'hC,
    ST_UPD_IR = 4'hD,
    ST_CAP_IR = 4'hE,
    ST_RESET  = 4'hF
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYP = 2'd0,
    PATH_ID  = 2'd1,
    PATH_BSR = 2'd2
  } dr_path_e;

  // Next controller state for a given mode-select sample.
  function automatic tap_state_e tap_next(tap_state_e s, logic tms);
    tap_state_e n;
    case (s)
      ST_RESET:  n = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = tms ? ST_SEL_DR : ST_IDLE;
      default:   n = ST_RESET;
    endcase
    return n;
  endfunction

  function automatic logic in_shift(tap_state_e s);
    return (s == ST_SH_IR) || (s == ST_SH_DR);
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state_o
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_o <= ST_RESET;
    else         state_o <= tap_next(state_o, tms);
  end

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
#(
  parameter int              IR_W       = 3,
  parameter logic [IR_W-1:0] OP_EXTEST  = 3'b000,
  parameter logic [IR_W-1:0] OP_IDCODE  = 3'b001,
  parameter logic [IR_W-1:0] OP_SAMPLEZ = 3'b010,
  parameter logic [IR_W-1:0] OP_SAMPLE  = 3'b100,
  parameter logic [IR_W-1:0] OP_BYPASS  = 3'b111
) (
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state_i,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_sr_o,
  output logic [IR_W-1:0] ir_q_o,
  output dr_path_e        path_o
);

  // Capture pattern: low two bits 01, upper bits zero.
  localparam logic [IR_W-1:0] IR_CAP = IR_W'(1);

  // Opcode to data-path decode; any code not named selects bypass.
  function automatic dr_path_e decode(logic [IR_W-1:0] op);
    dr_path_e p;
    if (op == OP_BYPASS)      p = PATH_BYP;
    else if (op == OP_IDCODE) p = PATH_ID;
    else if ((op == OP_EXTEST) || (op == OP_SAMPLEZ) || (op == OP_SAMPLE))
      p = PATH_BSR;
    else                      p = PATH_BYP;
    return p;
  endfunction

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr_o <= IR_CAP;
    end else begin
      case (state_i)
        ST_CAP_IR: ir_sr_o <= IR_CAP;
        ST_SH_IR:  ir_sr_o <= {tdi, ir_sr_o[IR_W-1:1]};
        default:   ir_sr_o <= ir_sr_o;
      endcase
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                    ir_q_o <= OP_IDCODE;
    else if (state_i == ST_RESET)   ir_q_o <= OP_IDCODE;
    else if (state_i == ST_UPD_IR)  ir_q_o <= ir_sr_o;
  end

  assign path_o = decode(ir_q_o);

endmodule

// File: rtl/scan_tap_dr_bank.sv
module scan_tap_dr_bank
  import scan_tap_pkg::*;
#(
  parameter int          BSR_LEN  = 16,
  parameter logic [31:0] ID_VALUE = 32'h1A5C_3E27
) (
  input  logic               tck,
  input  logic               trst_n,
  input  tap_state_e         state_i,
  input  dr_path_e           path_i,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pins_i,
  output logic               dr_lsb_o,
  output logic               byp_o
);

  localparam int          ID_W     = 32;
  localparam logic [ID_W-1:0] ID_FIXED = ID_VALUE | ID_W'(1);

  logic               cap_w, sh_w;
  logic [ID_W-1:0]    id_sr;
  logic [BSR_LEN-1:0] bsr_sr;

  assign cap_w = (state_i == ST_CAP_DR);
  assign sh_w  = (state_i == ST_SH_DR);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) byp_o <= 1'b0;
    else if (path_i == PATH_BYP) begin
      if (cap_w)     byp_o <= 1'b0;
      else if (sh_w) byp_o <= tdi;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) id_sr <= '0;
    else if (path_i == PATH_ID) begin
      if (cap_w)     id_sr <= ID_FIXED;
      else if (sh_w) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) bsr_sr <= '0;
    else if (path_i == PATH_BSR) begin
      if (cap_w)     bsr_sr <= pins_i;
      else if (sh_w) bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
    end
  end

  always_comb begin
    case (path_i)
      PATH_ID:  dr_lsb_o = id_sr[0];
      PATH_BSR: dr_lsb_o = bsr_sr[0];
      default:  dr_lsb_o = byp_o;
    endcase
  end

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int              BSR_LEN    = 16,
  parameter logic [31:0]     ID_VALUE   = 32'h1A5C_3E27,
  parameter int              IR_W       = 3,
  parameter logic [IR_W-1:0] OP_EXTEST  = 3'b000,
  parameter logic [IR_W-1:0] OP_IDCODE  = 3'b001,
  parameter logic [IR_W-1:0] OP_SAMPLEZ = 3'b010,
  parameter logic [IR_W-1:0] OP_SAMPLE  = 3'b100,
  parameter logic [IR_W-1:0] OP_BYPASS  = 3'b111
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] bsr_pins,
  output logic               tdo,
  output logic               tdo_oe
);

  tap_state_e      state_w;
  logic [IR_W-1:0] ir_sr_w;
  logic [IR_W-1:0] ir_q_w;
  dr_path_e        path_w;
  logic            dr_lsb_w;
  logic            byp_w;
  logic            shift_ir_w, shift_dr_w;
  logic            tdo_q, oe_q;

  scan_tap_fsm u_fsm (
    .tck     (tck),
    .trst_n  (trst_n),
    .tms     (tms),
    .state_o (state_w)
  );

  scan_tap_ir #(
    .IR_W       (IR_W),
    .OP_EXTEST  (OP_EXTEST),
    .OP_IDCODE  (OP_IDCODE),
    .OP_SAMPLEZ (OP_SAMPLEZ),
    .OP_SAMPLE  (OP_SAMPLE),
    .OP_BYPASS  (OP_BYPASS)
  ) u_ir (
    .tck     (tck),
    .trst_n  (trst_n),
    .state_i (state_w),
    .tdi     (tdi),
    .ir_sr_o (ir_sr_w),
    .ir_q_o  (ir_q_w),
    .path_o  (path_w)
  );

  scan_tap_dr_bank #(
    .BSR_LEN  (BSR_LEN),
    .ID_VALUE (ID_VALUE)
  ) u_dr (
    .tck      (tck),
    .trst_n   (trst_n),
    .state_i  (state_w),
    .path_i   (path_w),
    .tdi      (tdi),
    .pins_i   (bsr_pins),
    .dr_lsb_o (dr_lsb_w),
    .byp_o    (byp_w)
  );

  assign shift_ir_w = (state_w == ST_SH_IR);
  assign shift_dr_w = (state_w == ST_SH_DR);

  // Falling-edge output stage: data and enable retimed half a cycle late.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= in_shift(state_w);
      if (shift_ir_w)      tdo_q <= ir_sr_w[0];
      else if (shift_dr_w) tdo_q <= dr_lsb_w;
    end
  end

  assign tdo    = tdo_q;
  assign tdo_oe = oe_q;

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
#(
  parameter int              IR_W      = 3,
  parameter logic [IR_W-1:0] OP_IDCODE = 3'b001
) (
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_q,
  input logic [IR_W-1:0] ir_sr,
  input dr_path_e        path,
  input logic            byp,
  input logic            tdo_oe
);

  logic [2:0] hi_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)   hi_cnt <= 3'd0;
    else if (tms)  hi_cnt <= (hi_cnt == 3'd5) ? 3'd5 : hi_cnt + 3'd1;
    else           hi_cnt <= 3'd0;
  end

  assert_reset_hold_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET && tms) |=> (state == ST_RESET));

  assert_five_high_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (hi_cnt == 3'd5) |-> (state == ST_RESET));

  assert_reset_idcode_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET) |=> (ir_q == OP_IDCODE));

  assert_ir_capture_R5: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_sr[1:0] == 2'b01));

  assert_ir_hold_R7: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_UPD_IR && state != ST_RESET) |=> $stable(ir_q));

  assert_bypass_clear_R8: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_DR && path == PATH_BYP) |=> !byp);

  assert_oe_window_R4: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == ((state == ST_SH_IR) || (state == ST_SH_DR)));

endmodule

bind scan_tap scan_tap_chk #(
  .IR_W      (IR_W),
  .OP_IDCODE (OP_IDCODE)
) u_chk (
  .tck    (tck),
  .trst_n (trst_n),
  .tms    (tms),
  .state  (state_w),
  .ir_q   (ir_q_w),
  .ir_sr  (ir_sr_w),
  .path   (path_w),
  .byp    (byp_w),
  .tdo_oe (tdo_oe)
);

// File: tb/scan_tap_tb.sv
`timescale 1ns/1ps
module scan_tap_tb;

  localparam int          BL     = 16;
  localparam logic [31:0] ID_EXP = 32'h1A5C_3E27;

  // bench-side state numbering
  localparam int M_TLR = 0,  M_RTI = 1,  M_SDR = 2,  M_CDR = 3;
  localparam int M_SHD = 4,  M_X1D = 5,  M_PD  = 6,  M_X2D = 7;
  localparam int M_UD  = 8,  M_SIR = 9,  M_CIR = 10, M_SHI = 11;
  localparam int M_X1I = 12, M_PI  = 13, M_X2I = 14, M_UI  = 15;

  int nxt_lo [16] = '{1, 1, 3, 4, 4, 6, 6, 4, 1, 10, 11, 11, 13, 13, 11, 1};
  int nxt_hi [16] = '{0, 2, 9, 5, 5, 8, 7, 8, 2, 0, 12, 12, 15, 14, 15, 2};

  logic          tck = 1'b0;
  logic          trst_n, tms, tdi;
  logic [BL-1:0] pins;
  logic          tdo, tdo_oe;

  int checks = 0;
  int bad    = 0;

  // reference model
  int        ms;
  bit [2:0]  m_ir, m_irsr;
  bit        m_byp;
  bit [31:0] m_id;
  bit [BL-1:0] m_bsr;
  bit        m_tdo;

  scan_tap #(.BSR_LEN(BL), .ID_VALUE(ID_EXP)) u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .bsr_pins(pins), .tdo(tdo), .tdo_oe(tdo_oe)
  );

  always #2 tck = ~tck;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int m_path();
    if (m_ir == 3'b001) return 1;
    if (m_ir == 3'b000 || m_ir == 3'b010 || m_ir == 3'b100) return 2;
    return 0;
  endfunction

  task automatic tick(input bit t_tms, input bit t_tdi);
    int p;
    tms = t_tms;
    tdi = t_tdi;
    @(posedge tck);
    p = m_path();
    case (ms)
      M_TLR: m_ir = 3'b001;
      M_CIR: m_irsr = 3'b001;
      M_SHI: m_irsr = {t_tdi, m_irsr[2:1]};
      M_UI:  m_ir = m_irsr;
      M_CDR: begin
        if (p == 1) m_id = ID_EXP | 32'h1;
        else if (p == 2) m_bsr = pins;
        else m_byp = 1'b0;
      end
      M_SHD: begin
        if (p == 1) m_id = {t_tdi, m_id[31:1]};
        else if (p == 2) m_bsr = {t_tdi, m_bsr[BL-1:1]};
        else m_byp = t_tdi;
      end
      default: ;
    endcase
    ms = t_tms ? nxt_hi[ms] : nxt_lo[ms];
    @(negedge tck);
    #1;
    if (ms == M_SHI) m_tdo = m_irsr[0];
    else if (ms == M_SHD) begin
      p = m_path();
      m_tdo = (p == 1) ? m_id[0] : (p == 2) ? m_bsr[0] : m_byp;
    end
    chk(tdo_oe === ((ms == M_SHI) || (ms == M_SHD)), "R4", "tdo_oe vs model (R1 path)",
        64'(tdo_oe), 64'((ms == M_SHI) || (ms == M_SHD)));
    if (tdo_oe === 1'b1)
      chk(tdo === m_tdo, "R6", "tdo vs model", 64'(tdo), 64'(m_tdo));
  endtask

  // From Run-Test/Idle: scan n bits through the data path, return to idle.
  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic shift_ir(input logic [2:0] code, output logic [2:0] dout);
    dout = '0;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      dout[i] = tdo;
      tick(i == 2, code[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [63:0] o64;
    logic [2:0]  o3;
    logic [2:0]  rsv [3];
    logic [2:0]  bops [3];
    logic [BL-1:0] pv [3];
    rsv  = '{3'b011, 3'b101, 3'b110};
    bops = '{3'b100, 3'b000, 3'b010};
    pv   = '{16'hC3A1, 16'h5E17, 16'h8D42};

    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; pins = 16'h0000;
    ms = M_TLR; m_ir = 3'b001; m_irsr = 3'b001; m_byp = 0; m_id = 0; m_bsr = 0; m_tdo = 0;
    repeat (3) @(negedge tck);
    #1;
    chk(tdo_oe === 1'b0, "R3", "tdo_oe during reset", 64'(tdo_oe), 64'd0);
    trst_n = 1'b1;
    tick(0, 0);

    // default instruction after reset is IDCODE
    shift_dr(32, 64'h0, o64);
    chk(o64[31:0] == ID_EXP, "R3", "IDCODE active after reset", o64, 64'(ID_EXP));
    chk(o64[0] == 1'b1, "R9", "identification bit0", 64'(o64[0]), 64'd1);

    // BYPASS and instruction capture pattern
    shift_ir(3'b111, o3);
    chk(o3 == 3'b001, "R5", "capture-IR pattern", 64'(o3), 64'd1);
    shift_dr(8, 64'hA5, o64);
    chk(o64[7:0] == 8'h4A, "R8", "bypass one-bit delay", o64, 64'h4A);

    // reserved codes
    foreach (rsv[k]) begin
      shift_ir(rsv[k], o3);
      chk(o3 == 3'b001, "R5", "capture-IR pattern", 64'(o3), 64'd1);
      shift_dr(8, 64'h3C, o64);
      chk(o64[7:0] == 8'h78, "R11", "reserved code acts as bypass", o64, 64'h78);
    end

    // boundary instructions: capture pins, then check length
    foreach (bops[k]) begin
      pins = pv[k];
      shift_ir(bops[k], o3);
      shift_dr(BL + 4, 64'hF0F0F, o64);
      chk(o64[BL-1:0] == pv[k], "R10", "boundary capture of pins", o64, 64'(pv[k]));
      chk(o64[BL+3:BL] == 4'hF, "R6", "boundary path length", 64'(o64[BL+3:BL]), 64'hF);
    end

    // explicit IDCODE load and full identification path length
    shift_ir(3'b001, o3);
    shift_dr(36, 64'h5, o64);
    chk(o64[31:0] == ID_EXP, "R9", "identification value", o64, 64'(ID_EXP));
    chk(o64[35:32] == 4'h5, "R6", "identification path length", 64'(o64[35:32]), 64'h5);

    // five-high reset from inside Shift-DR under BYPASS
    shift_ir(3'b111, o3);
    tick(1, 0); tick(0, 0); tick(0, 0);
    repeat (5) tick(1, 0);
    tick(0, 0);
    shift_dr(32, 64'h0, o64);
    chk(o64[31:0] == ID_EXP, "R2", "five-high reset from Shift-DR", o64, 64'(ID_EXP));

    // five-high reset from Pause-IR with a pending code
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    tick(0, 1); tick(0, 1); tick(1, 1); tick(0, 0);
    repeat (5) tick(1, 0);
    tick(0, 0);
    shift_dr(32, 64'h0, o64);
    chk(o64[31:0] == ID_EXP, "R2", "five-high reset from Pause-IR", o64, 64'(ID_EXP));

    // late update through Pause-IR: code 111 only active after Update-IR
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    tick(0, 1); tick(0, 1); tick(1, 1);
    tick(0, 0); tick(0, 0); tick(1, 0); tick(1, 0); tick(0, 0);
    shift_dr(8, 64'h96, o64);
    chk(o64[7:0] == 8'h2C, "R7", "instruction applied at Update-IR", o64, 64'h2C);

    // Pause-DR detour under IDCODE
    shift_ir(3'b001, o3);
    o64 = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 32; i++) begin
      o64[i] = tdo;
      if (i == 31) tick(1, 0);
      else if (i == 9) begin
        tick(1, 0); tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0);
      end else tick(0, 0);
    end
    tick(1, 0); tick(0, 0);
    chk(o64[31:0] == ID_EXP, "R1", "Pause-DR detour keeps bits", o64, 64'(ID_EXP));

    // asynchronous reset mid-shift
    tick(1, 0); tick(0, 0); tick(0, 0);
    #0.5;
    trst_n = 1'b0;
    #0.5;
    chk(tdo_oe === 1'b0, "R3", "async reset clears tdo_oe", 64'(tdo_oe), 64'd0);
    ms = M_TLR; m_ir = 3'b001; m_irsr = 3'b001; m_byp = 0; m_id = 0; m_bsr = 0;
    @(negedge tck); #1;
    trst_n = 1'b1;
    tick(0, 0);
    shift_dr(32, 64'h0, o64);
    chk(o64[31:0] == ID_EXP, "R3", "IDCODE after async reset", o64, 64'(ID_EXP));

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule